// File: doc/BRIEF.md
# Redirection-Table Interrupt Router

This block turns up to 24 interrupt input lines into interrupt messages for processors. Each line has its own programmable routing entry. The entry holds a vector, a delivery mode, a destination ID, a destination-mode bit, a polarity bit, a trigger-mode bit, a mask bit and a read-only remote-pending flag.

A line whose effective level rises produces a request. The request leaves the block as one message on a single valid/ready output port. If the line is already waiting, or a level-mode line still has an unacknowledged message outstanding, the request is merged into the earlier one. A merged request is reported as a one-cycle coalesced pulse for that line.

An end-of-interrupt (EOI) input carries a vector. It frees level-mode entries with that vector, so that a line still held active is serviced again. Choosing which processor takes a message is left to the receiver.

Back-pressure works as follows. The message port is valid/ready. Once `msg_valid` is high, it stays high with the same line and payload until the cycle in which `msg_ready` is also high. A line that becomes pending while the port is stalled waits behind the held message. Requests that arrive during a stall are kept as pending bits, so back-pressure never loses a request. They merge only according to the coalescing rules.

Top module: `irq_redirect_router`

## Requirements
- R1: After reset every entry reads 0x00008000 (masked, all other fields zero), `msg_valid` is low and no coalesced pulse is active.
- R2: The entry layout is vector [7:0], delivery mode [10:8], logical-destination bit [11], active-low polarity [12], remote-pending [13], level-trigger [14], mask [15] and destination [23:16].
  - A write to an address below 24 stores every field except bit 13, which writes cannot set.
  - Writing an entry with bit 14 low clears its remote-pending flag.
  - Reads are combinational.
  - Writes to addresses 24 to 31 are ignored, and reads there return zero.
- R3: The effective level of a line is its raw input XOR bit 12. A request is raised only when the effective level rises from low to high.
- R4: An edge-mode line (bit 14 = 0) that rises gives exactly one message. A line held high gives no further message until it falls and rises again.
- R5: Level-mode lines and the remote-pending flag.
  - Accepting a message from a level-mode line sets its remote-pending flag.
  - While the flag is set, a new rise on that line gives no message and is reported as coalesced.
- R6: A rise on an unmasked line that is already pending, or that is in level mode with remote-pending set, pulses `coal_pulse[line]` for exactly one cycle, in the cycle after the rise.
- R7: A rise on a masked line produces neither a message nor a coalesced pulse.
- R8: EOI handling.
  - An EOI whose vector equals the vector of a level-mode entry with remote-pending set clears that flag.
  - If that line's effective level is still high and the entry is unmasked, the line sends a new message.
  - A non-matching EOI changes nothing.
- R9: Pending lines are issued one message per accepted handshake, lowest line index first.
- R10: While `msg_valid` is high and `msg_ready` is low, the line and payload on the port stay unchanged, even if a lower-index line becomes pending. This holds as long as no entry is rewritten.
- R11: Messages from line 0 always carry the fixed boot destination ID (parameter, default 0x00) and physical mode, whatever entry 0 holds.
- R12: A message carries its line index and the entry's vector, destination, destination-mode, delivery-mode and trigger-mode fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | 24 | Raw interrupt line levels |
| cfg_we | input | 1 | Entry write strobe |
| cfg_addr | input | 5 | Entry index for read and write |
| cfg_wdata | input | 32 | Entry write data |
| cfg_rdata | output | 32 | Entry read data (combinational) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts message |
| msg_pin | output | 5 | Source line of the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination ID |
| msg_dest_logical | output | 1 | 1 = logical destination, 0 = physical |
| msg_dmode | output | 3 | Message delivery mode |
| msg_level_trig | output | 1 | Message came from a level-mode line |
| coal_pulse | output | 24 | One-cycle coalesced report per line |

## Verification
The hardest state to reach is a level-mode line that is still asserted while its remote-pending flag is set. An EOI in that state must both free the flag and reissue the message. The bench reaches it by accepting a level message and leaving the line high. It then sends a non-matching EOI, which must change nothing, and after that the matching vector, which must bring a second message. Holding `msg_ready` low while raising two higher lines, and then a lower one during the stall, exercises the port's hold rule and the lowest-first order.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DM_W   = 3;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic              rem;
    logic              pol;
    logic              logical;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vector;
  } rdr_entry_t;

  localparam int ENT_W = $bits(rdr_entry_t);

  localparam rdr_entry_t ENT_RESET = '{dest: '0, mask: 1'b1, level: 1'b0,
                                       rem: 1'b0, pol: 1'b0, logical: 1'b0,
                                       dmode: '0, vector: '0};
endpackage

// File: rtl/rdr_pin_slice.sv
module rdr_pin_slice
  import rdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             wr_en,
  input  rdr_entry_t       wr_ent,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             grant,
  output rdr_entry_t       ent_o,
  output logic             pend_o,
  output logic             coal_o
);
  rdr_entry_t ent_q, ent_d;
  logic irr_q, pend_q, coal_q;
  logic eff, rise, blocked, eoi_clr, svc, coal_d;

  always_comb begin
    eff     = raw ^ ent_q.pol;
    rise    = eff & ~irr_q;
    blocked = pend_q | (ent_q.level & ent_q.rem);
    eoi_clr = eoi_valid & ent_q.level & ent_q.rem & (eoi_vector == ent_q.vector);
    svc     = ~ent_q.mask & ((rise & ~blocked) | (eoi_clr & eff & ~pend_q));
    coal_d  = ~ent_q.mask & rise & blocked;

    ent_d = ent_q;
    if (grant && ent_q.level) ent_d.rem = 1'b1;
    else if (eoi_clr)         ent_d.rem = 1'b0;
    if (wr_en) begin
      ent_d     = wr_ent;
      ent_d.rem = wr_ent.level & ent_q.rem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q  <= ENT_RESET;
      irr_q  <= 1'b0;
      pend_q <= 1'b0;
      coal_q <= 1'b0;
    end else begin
      ent_q  <= ent_d;
      irr_q  <= eff;
      pend_q <= (pend_q & ~grant) | svc;
      coal_q <= coal_d;
    end
  end

  assign ent_o  = ent_q;
  assign pend_o = pend_q;
  assign coal_o = coal_q;

  // R5
  lvl_pend_no_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ent_q.level) |-> !ent_q.rem);
  // R7
  mask_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !$past(ent_q.mask));
  // R6
  coal_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coal_q |-> !$past(irr_q));
endmodule

// File: rtl/rdr_first_set.sv
module rdr_first_set #(
  parameter int N = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router
  import rdr_pkg::*;
#(
  parameter int               NUM_PINS = 24,
  parameter logic [DEST_W-1:0] BOOT_ID = 8'h00,
  localparam int              ADDR_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [ADDR_W-1:0]   msg_pin,
  output logic [VEC_W-1:0]    msg_vector,
  output logic [DEST_W-1:0]   msg_dest,
  output logic                msg_dest_logical,
  output logic [DM_W-1:0]     msg_dmode,
  output logic                msg_level_trig,
  output logic [NUM_PINS-1:0] coal_pulse
);
  rdr_entry_t          ents [NUM_PINS];
  rdr_entry_t          wr_ent, cur_ent;
  logic [NUM_PINS-1:0] pend_vec, grant_vec, low_mask;
  logic [ADDR_W-1:0]   arb_idx, cur_idx, lock_idx;
  logic                arb_any, lock_q, addr_ok;

  assign wr_ent  = rdr_entry_t'(cfg_wdata[ENT_W-1:0]);
  assign addr_ok = (32'(cfg_addr) < NUM_PINS);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    rdr_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw       (pin_level[g]),
      .wr_en     (cfg_we && addr_ok && (32'(cfg_addr) == g)),
      .wr_ent    (wr_ent),
      .eoi_valid (eoi_valid),
      .eoi_vector(eoi_vector),
      .grant     (grant_vec[g]),
      .ent_o     (ents[g]),
      .pend_o    (pend_vec[g]),
      .coal_o    (coal_pulse[g])
    );
  end

  rdr_first_set #(.N(NUM_PINS)) u_arb (
    .req(pend_vec),
    .idx(arb_idx),
    .any(arb_any)
  );

  always_comb begin
    cur_idx   = lock_q ? lock_idx : arb_idx;
    msg_valid = lock_q | arb_any;
    cur_ent   = ents[cur_idx];
    grant_vec = '0;
    grant_vec[cur_idx] = msg_valid & msg_ready;
    low_mask  = (NUM_PINS'(1) << cur_idx) - NUM_PINS'(1);
    cfg_rdata = addr_ok ? 32'(ents[cfg_addr]) : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      lock_idx <= '0;
    end else begin
      lock_q   <= msg_valid & ~msg_ready;
      lock_idx <= cur_idx;
    end
  end

  assign msg_pin          = cur_idx;
  assign msg_vector       = cur_ent.vector;
  assign msg_dmode        = cur_ent.dmode;
  assign msg_level_trig   = cur_ent.level;
  assign msg_dest         = (cur_idx == '0) ? BOOT_ID : cur_ent.dest;
  assign msg_dest_logical = (cur_idx == '0) ? 1'b0 : cur_ent.logical;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !cfg_we) |=>
      (msg_valid && $stable(msg_pin) && $stable(msg_vector) && $stable(msg_dest)));
  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !lock_q) |-> ((pend_vec & low_mask) == '0));
  // R9
  valid_has_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> pend_vec[msg_pin]);
  // R11
  pin0_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_pin == '0) |-> (msg_dest == BOOT_ID && !msg_dest_logical));
endmodule

// File: tb/irq_redirect_router_tb.sv
`timescale 1ns/1ps
module irq_redirect_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [4:0]  msg_pin;
  logic [7:0]  msg_vector, msg_dest;
  logic        msg_dest_logical, msg_level_trig;
  logic [2:0]  msg_dmode;
  logic [23:0] coal_pulse;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_redirect_router dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pins),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
    .msg_dmode(msg_dmode), .msg_level_trig(msg_level_trig), .coal_pulse(coal_pulse)
  );

  typedef struct packed {
    logic [4:0] pin;
    logic [7:0] vec;
    logic [2:0] dm;
    logic       lg;
    logic       pol;
    logic [7:0] dest;
    logic [7:0] exp_dest;
    logic       exp_lg;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{5'd0,  8'h30, 3'd1, 1'b1, 1'b0, 8'h55, 8'h00, 1'b0},
    '{5'd1,  8'h31, 3'd0, 1'b1, 1'b1, 8'h0F, 8'h0F, 1'b1},
    '{5'd23, 8'hEE, 3'd4, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},
    '{5'd16, 8'h80, 3'd7, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b1},
    '{5'd0,  8'h22, 3'd0, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0},
    '{5'd10, 8'h01, 3'd2, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}
  };

  function automatic logic [31:0] mk(logic [7:0] vec, logic [2:0] dm, logic lg,
                                     logic pol, logic lvl, logic msk, logic [7:0] dest);
    return {8'h00, dest, msk, lvl, 1'b0, pol, lg, dm, vec};
  endfunction

  task automatic cheq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #0.1;
    d = cfg_rdata;
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, d);  cheq("R1 entry0 reset", d, 32'h00008000);
    rd(5'd23, d); cheq("R1 entry23 reset", d, 32'h00008000);
    cheq("R1 msg_valid", msg_valid, 0);
    cheq("R1 coal", coal_pulse, 0);

    // R2 out-of-range address and read-only remote bit
    wr(5'd30, 32'h00FF0041);
    rd(5'd30, d); cheq("R2 addr30 read zero", d, 0);
    wr(5'd5, mk(8'h41, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'h12) | 32'h2000);
    rd(5'd5, d);  cheq("R2 entry5 store, remote not writable", d, 32'h0012CA41);

    // R3 R4 R11 R12: table of edge-mode lines
    foreach (ROWS[i]) begin
      row_t r = ROWS[i];
      @(negedge clk); pins[r.pin] = r.pol;
      wr(r.pin, mk(r.vec, r.dm, r.lg, r.pol, 1'b0, 1'b1, r.dest));
      wr(r.pin, mk(r.vec, r.dm, r.lg, r.pol, 1'b0, 1'b0, r.dest));
      cheq("R3 no message at inactive level", msg_valid, 0);
      pins[r.pin] = ~r.pol;
      @(negedge clk);
      cheq("R4 valid after rise", msg_valid, 1);
      cheq("R12 pin", msg_pin, r.pin);
      cheq("R12 vector", msg_vector, r.vec);
      cheq("R12 dmode", msg_dmode, r.dm);
      cheq("R12 trig", msg_level_trig, 0);
      cheq("R11 R12 dest", msg_dest, r.exp_dest);
      cheq("R11 R12 dest mode", msg_dest_logical, r.exp_lg);
      accept();
      cheq("R4 single message", msg_valid, 0);
      pins[r.pin] = r.pol;
      wr(r.pin, mk(r.vec, r.dm, r.lg, r.pol, 1'b0, 1'b1, r.dest));
    end

    // R4 R6 edge line 3: hold, then re-rise while pending
    wr(5'd3, mk(8'h23, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    pins[3] = 1'b1; @(negedge clk);
    accept();
    repeat (3) @(negedge clk);
    cheq("R4 held high gives no more", msg_valid, 0);
    pins[3] = 1'b0; @(negedge clk);
    pins[3] = 1'b1; @(negedge clk);
    cheq("R4 new rise valid", msg_valid, 1);
    pins[3] = 1'b0; @(negedge clk);
    pins[3] = 1'b1; @(negedge clk);
    cheq("R6 coalesced pulse", coal_pulse, 24'h000008);
    @(negedge clk);
    cheq("R6 pulse one cycle", coal_pulse, 0);
    accept();
    cheq("R6 merged to one message", msg_valid, 0);
    pins[3] = 1'b0;

    // R5 R8 level line 7
    wr(5'd7, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02));
    pins[7] = 1'b1; @(negedge clk);
    cheq("R5 level message", msg_level_trig, 1);
    accept();
    rd(5'd7, d); cheq("R5 remote set", d[13], 1);
    pins[7] = 1'b0; @(negedge clk);
    pins[7] = 1'b1; @(negedge clk);
    cheq("R5 coalesced while remote", coal_pulse, 24'h000080);
    cheq("R5 no message while remote", msg_valid, 0);
    eoi(8'h41);
    rd(5'd7, d); cheq("R8 other vector ignored", d[13], 1);
    cheq("R8 other vector no message", msg_valid, 0);
    eoi(8'h40);
    cheq("R8 reissue after EOI", msg_valid, 1);
    cheq("R8 reissue pin", msg_pin, 7);
    accept();
    pins[7] = 1'b0;
    eoi(8'h40);
    rd(5'd7, d); cheq("R8 remote cleared", d[13], 0);
    cheq("R8 no message when line low", msg_valid, 0);

    // R7 masked line
    wr(5'd9, mk(8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00));
    pins[9] = 1'b1; @(negedge clk);
    cheq("R7 masked no message", msg_valid, 0);
    cheq("R7 masked no coalesce", coal_pulse, 0);
    pins[9] = 1'b0;

    // R9 R10 arbitration and stall
    wr(5'd2,  mk(8'h62, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    wr(5'd12, mk(8'h6C, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    wr(5'd20, mk(8'h74, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    pins[12] = 1'b1; pins[20] = 1'b1; @(negedge clk);
    cheq("R9 lowest of 12,20", msg_pin, 12);
    repeat (2) @(negedge clk);
    pins[2] = 1'b1; @(negedge clk);
    cheq("R10 held during stall", msg_pin, 12);
    cheq("R10 held vector", msg_vector, 8'h6C);
    accept();
    cheq("R9 next lowest", msg_pin, 2);
    accept();
    cheq("R9 last", msg_pin, 20);
    accept();
    cheq("R9 drained", msg_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule